// File: doc/BRIEF.md
# I/O Window Claim Unit

This block is the configuration slice of one function that owns a small I/O window. It holds two registers that software reaches through a dword-addressed configuration port. The first is a 32-bit I/O base register whose upper address bits are programmable; its low bits are fixed to mark the window as I/O space. The second is a 16-bit subsystem vendor identifier that accepts exactly one write after reset and is read-only from then on.

On the cycle side, the block decides combinationally whether an incoming 1-, 2- or 4-byte I/O request should be claimed. A request is claimed only if every byte it touches lies in the 8-byte window starting at the programmed base. The function must also be fully allowed to respond: power state D0, I/O decoding enabled, the function switched on, and not fuse-disabled.

Both interfaces are single-beat and never back-pressure. A configuration write is taken on any clock edge where `cfg_valid` and `cfg_write` are high, so the port behaves as if its ready were always asserted. Read data follows `cfg_dw_off` combinationally. An I/O request is judged in the same cycle that `io_valid` is high, and the block never stalls it.

Top module: `iobar_claim_unit`

## Requirements
- R1: After reset, the base register (dword offset 08h) reads 0x00000001 and the vendor identifier (dword offset 0Bh, bits 15:0) reads 0x0000.
- R2: A configuration write to dword offset 08h updates base bits 7:6 only when cfg_be[0] is set and bits 15:8 only when cfg_be[1] is set.
- R3: Reading dword offset 08h always gives bits 31:16 and 5:1 as zero and bit 0 as one, whatever has been written.
- R4: With access allowed, a request whose address A and size N (io_size 00 = 1 byte, 01 = 2, 10 = 4) satisfy base <= A and A + N <= base + 8 asserts io_claim.
- R5: A request with any byte outside the 8-byte window, including one that starts inside and runs past its end, is not claimed; io_size 11 is never claimed.
- R6: io_claim stays low when pm_state is not 00 (01 = D1, 10 = D2, 11 = D3), when io_en is low, when fn_enabled is low, or when fuse_disable is high.
- R7: The first write to dword offset 0Bh with cfg_be[0] or cfg_be[1] set stores the enabled bytes and locks the identifier; any later write leaves both bytes unchanged until reset.
- R8: A write to dword offset 0Bh that enables neither cfg_be[0] nor cfg_be[1] changes nothing and does not lock the identifier.
- R9: io_claim depends combinationally on the request, so it is valid in the cycle the request is presented, and it is low whenever io_valid is low.
- R10: Reads of any other dword offset, and of bits 31:16 of offset 0Bh, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_dw_off | input | 6 | Dword offset in configuration space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_off |
| io_valid | input | 1 | I/O request present |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | 00 = 1 byte, 01 = 2, 10 = 4, 11 = invalid |
| io_en | input | 1 | I/O decode enable |
| pm_state | input | 2 | Power state, 00 = D0 through 11 = D3 |
| fn_enabled | input | 1 | Function switched on |
| fuse_disable | input | 1 | Function fused off |
| io_claim | output | 1 | Claim for the current request |

## Verification
The hardest case to reach from the ports is a request that starts inside the window but runs past its top byte. It is reached only with a 2- or 4-byte size at one of the last three offsets, and it must be separated from a correct claim of the same start address with a smaller size. The stimulus therefore sweeps every address from 16 bytes below each programmed base to 24 bytes above it, using all four size codes. That sweep is repeated for bases at the bottom and top of the address space and at values that come from writes with unaligned or partial byte enables. The write-once lock is driven to its edge by first writing the identifier with only the upper byte enables, which must not lock. The bench then writes one low byte and retries with both bytes.

// File: rtl/iobar_claim_pkg.sv
package iobar_claim_pkg;
  localparam int unsigned CFG_OFF_W   = 6;
  localparam logic [CFG_OFF_W-1:0] BAR_DW_OFF  = 6'h08;
  localparam logic [CFG_OFF_W-1:0] SVID_DW_OFF = 6'h0B;

  typedef enum logic [1:0] {
    PM_D0 = 2'b00,
    PM_D1 = 2'b01,
    PM_D2 = 2'b10,
    PM_D3 = 2'b11
  } pm_state_e;

  typedef enum logic [1:0] {
    IO_SZ_1   = 2'b00,
    IO_SZ_2   = 2'b01,
    IO_SZ_4   = 2'b10,
    IO_SZ_BAD = 2'b11
  } io_size_e;
endpackage

// File: rtl/iobar_base_reg.sv
module iobar_base_reg #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ALIGN_LSB = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [3:0]                  be,
  input  logic [31:0]                 wdata,
  output logic [ADDR_W-1:ALIGN_LSB]   base_q,
  output logic [31:0]                 rd_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      for (int b = ALIGN_LSB; b < ADDR_W; b++) begin
        if (be[b/8]) base_q[b] <= wdata[b];
      end
    end
  end

  // Fixed layout: upper reserved zero, low type bits zero, space bit one.
  always_comb begin
    rd_word = '0;
    rd_word[ADDR_W-1:ALIGN_LSB] = base_q;
    rd_word[0] = 1'b1;
  end
endmodule

// File: rtl/svid_once_reg.sv
module svid_once_reg #(
  parameter int unsigned ID_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ID_W/8-1:0]    be,
  input  logic [ID_W-1:0]      wdata,
  output logic [ID_W-1:0]      id_q,
  output logic                 locked_q
);
  localparam int unsigned NBYTES = ID_W / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      locked_q <= 1'b0;
    end else if (wr_en && !locked_q && (|be)) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (be[i]) id_q[i*8 +: 8] <= wdata[i*8 +: 8];
      end
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/io_window_decode.sv
module io_window_decode
  import iobar_claim_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned WIN_LSB   = 3
) (
  input  logic                       io_valid,
  input  logic [ADDR_W-1:0]          io_addr,
  input  logic [1:0]                 io_size,
  input  logic [ADDR_W-1:ALIGN_LSB]  base,
  input  logic                       access_ok,
  output logic                       claim
);
  localparam int unsigned SUM_W     = WIN_LSB + 2;
  localparam int unsigned WIN_BYTES = 1 << WIN_LSB;

  logic [SUM_W-1:0] nbytes;
  logic [SUM_W-1:0] end_off;
  logic             size_ok;
  logic             hi_hit;
  logic             mid_zero;
  logic             fits;

  always_comb begin
    size_ok = 1'b1;
    unique case (io_size_e'(io_size))
      IO_SZ_1: nbytes = SUM_W'(1);
      IO_SZ_2: nbytes = SUM_W'(2);
      IO_SZ_4: nbytes = SUM_W'(4);
      default: begin nbytes = '0; size_ok = 1'b0; end
    endcase
  end

  assign hi_hit  = (io_addr[ADDR_W-1:ALIGN_LSB] == base);
  assign end_off = SUM_W'(io_addr[WIN_LSB-1:0]) + nbytes;
  assign fits    = (end_off <= SUM_W'(WIN_BYTES));

  generate
    if (ALIGN_LSB > WIN_LSB) begin : g_gap
      assign mid_zero = (io_addr[ALIGN_LSB-1:WIN_LSB] == '0);
    end else begin : g_nogap
      assign mid_zero = 1'b1;
    end
  endgenerate

  assign claim = io_valid && access_ok && size_ok && hi_hit && mid_zero && fits;
endmodule

// File: rtl/iobar_claim_unit.sv
module iobar_claim_unit
  import iobar_claim_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned WIN_LSB   = 3,
  parameter int unsigned ID_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic                  cfg_write,
  input  logic [CFG_OFF_W-1:0]  cfg_dw_off,
  input  logic [3:0]            cfg_be,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic                  io_valid,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic [1:0]            io_size,
  input  logic                  io_en,
  input  logic [1:0]            pm_state,
  input  logic                  fn_enabled,
  input  logic                  fuse_disable,
  output logic                  io_claim
);
  localparam int unsigned ID_BYTES = ID_W / 8;

  logic                       bar_wr;
  logic                       svid_wr;
  logic [ADDR_W-1:ALIGN_LSB]  base_val;
  logic [31:0]                bar_word;
  logic [ID_W-1:0]            svid_val;
  logic                       svid_locked;
  logic                       access_ok;

  assign bar_wr  = cfg_valid && cfg_write && (cfg_dw_off == BAR_DW_OFF);
  assign svid_wr = cfg_valid && cfg_write && (cfg_dw_off == SVID_DW_OFF);

  iobar_base_reg #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(bar_wr), .be(cfg_be),
    .wdata(cfg_wdata), .base_q(base_val), .rd_word(bar_word)
  );

  svid_once_reg #(.ID_W(ID_W)) u_svid (
    .clk(clk), .rst_n(rst_n), .wr_en(svid_wr), .be(cfg_be[ID_BYTES-1:0]),
    .wdata(cfg_wdata[ID_W-1:0]), .id_q(svid_val), .locked_q(svid_locked)
  );

  assign access_ok = io_en && (pm_state_e'(pm_state) == PM_D0) && fn_enabled && !fuse_disable;

  io_window_decode #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .WIN_LSB(WIN_LSB)) u_dec (
    .io_valid(io_valid), .io_addr(io_addr), .io_size(io_size),
    .base(base_val), .access_ok(access_ok), .claim(io_claim)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_dw_off == BAR_DW_OFF)       cfg_rdata = bar_word;
    else if (cfg_dw_off == SVID_DW_OFF) cfg_rdata[ID_W-1:0] = svid_val;
  end
endmodule

// File: rtl/iobar_claim_chk.sv
module iobar_claim_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned ID_W      = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_valid,
  input logic                      cfg_write,
  input logic [5:0]                cfg_dw_off,
  input logic [3:0]                cfg_be,
  input logic [31:0]               cfg_rdata,
  input logic                      io_valid,
  input logic [ADDR_W-1:0]         io_addr,
  input logic                      io_en,
  input logic [1:0]                pm_state,
  input logic                      fn_enabled,
  input logic                      fuse_disable,
  input logic                      io_claim,
  input logic [ADDR_W-1:ALIGN_LSB] base_val,
  input logic [ID_W-1:0]           svid_val,
  input logic                      svid_locked
);
  // R6
  gate_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (pm_state == 2'b00 && io_en && fn_enabled && !fuse_disable));

  // R9
  idle_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !io_claim);

  // R4
  claim_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (io_addr[ADDR_W-1:ALIGN_LSB] == base_val));

  // R3
  bar_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw_off == 6'h08) |-> (cfg_rdata[ALIGN_LSB-1:0] == 1 && cfg_rdata[31:ADDR_W] == '0));

  // R7
  svid_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svid_locked |=> $stable(svid_val));

  // R7
  svid_lock_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_dw_off == 6'h0B && (|cfg_be[1:0])) |=> svid_locked);

  // R7
  svid_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svid_locked |=> svid_locked);
endmodule

bind iobar_claim_unit iobar_claim_chk #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
  .cfg_dw_off(cfg_dw_off), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
  .io_valid(io_valid), .io_addr(io_addr), .io_en(io_en), .pm_state(pm_state),
  .fn_enabled(fn_enabled), .fuse_disable(fuse_disable), .io_claim(io_claim),
  .base_val(base_val), .svid_val(svid_val), .svid_locked(svid_locked)
);

// File: tb/iobar_claim_unit_bench.sv
module iobar_claim_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_write = 1'b0;
  logic [5:0]  cfg_dw_off = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_en = 1'b1;
  logic [1:0]  pm_state = 2'b00;
  logic        fn_enabled = 1'b1;
  logic        fuse_disable = 1'b0;
  logic        io_claim;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iobar_claim_unit u_iobar_claim_unit (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_dw_off(cfg_dw_off), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_valid(io_valid), .io_addr(io_addr),
    .io_size(io_size), .io_en(io_en), .pm_state(pm_state),
    .fn_enabled(fn_enabled), .fuse_disable(fuse_disable), .io_claim(io_claim)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfg_wr(input logic [5:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_dw_off = off; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_chk(input string req, input logic [5:0] off, input logic [31:0] exp);
    cfg_dw_off = off;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  function automatic int size_bytes(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 0;
    endcase
  endfunction

  // R4 R5: sweep around the window with all size codes
  task automatic sweep_window(input int base);
    for (int off = -16; off < 24; off++) begin
      for (int s = 0; s < 4; s++) begin
        int a;
        int nb;
        logic exp;
        a  = (base + off) & 16'hFFFF;
        nb = size_bytes(2'(s));
        exp = (nb != 0) && (a >= base) && (a + nb <= base + 8);
        io_valid = 1'b1; io_addr = 16'(a); io_size = 2'(s);
        #1;
        check(exp ? "R4 claim inside window" : "R5 no claim outside window",
              {31'b0, io_claim}, {31'b0, exp});
      end
    end
    io_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    do_reset();
    // R1
    cfg_chk("R1 base reset", 6'h08, 32'h0000_0001);
    cfg_chk("R1 svid reset", 6'h0B, 32'h0000_0000);
    // R10
    cfg_chk("R10 other offset", 6'h00, 32'h0);
    cfg_chk("R10 other offset", 6'h0C, 32'h0);

    // R9: idle request never claims
    io_valid = 1'b0; io_addr = 16'h0000; io_size = 2'b00; #1;
    check("R9 idle no claim", {31'b0, io_claim}, 32'h0);
    sweep_window(0);

    // R2: partial byte enables
    cfg_wr(6'h08, 4'b0001, 32'hFFFF_FFFF);
    cfg_chk("R2 low byte only", 6'h08, 32'h0000_00C1);
    cfg_wr(6'h08, 4'b0010, 32'hAAAA_AAAA);
    cfg_chk("R2 high byte only", 6'h08, 32'h0000_AAC1);
    // R3: upper bytes ignored, fixed bits hold
    cfg_wr(6'h08, 4'b1100, 32'hFFFF_FFFF);
    cfg_chk("R3 upper ignored", 6'h08, 32'h0000_AAC1);
    sweep_window(16'hAAC0);
    cfg_wr(6'h08, 4'b1111, 32'hFFFF_FFFE);
    cfg_chk("R3 fixed bits", 6'h08, 32'h0000_FFC1);
    sweep_window(16'hFFC0);
    cfg_wr(6'h08, 4'b0011, 32'h0000_8A7F);
    cfg_chk("R3 masked low bits", 6'h08, 32'h0000_8A41);
    sweep_window(16'h8A40);
    cfg_wr(6'h08, 4'b0011, 32'h0000_0040);
    sweep_window(16'h0040);

    // R6: every gate combination at an in-window request; R9 same cycle
    for (int g = 0; g < 32; g++) begin
      logic exp;
      pm_state = 2'(g & 3); io_en = g[2]; fn_enabled = g[3]; fuse_disable = g[4];
      io_valid = 1'b1; io_addr = 16'h0042; io_size = 2'b01;
      #1;
      exp = (pm_state == 2'b00) && io_en && fn_enabled && !fuse_disable;
      check("R6 gating", {31'b0, io_claim}, {31'b0, exp});
    end
    io_valid = 1'b0; pm_state = 2'b00; io_en = 1'b1; fn_enabled = 1'b1; fuse_disable = 1'b0;

    // R8: write with only upper enables does not lock
    cfg_wr(6'h0B, 4'b1100, 32'h1234_5678);
    cfg_chk("R8 no change", 6'h0B, 32'h0);
    // R7: first low-byte write stores and locks
    cfg_wr(6'h0B, 4'b0001, 32'h0000_BEEF);
    cfg_chk("R7 first write", 6'h0B, 32'h0000_00EF);
    cfg_wr(6'h0B, 4'b0011, 32'h0000_FFFF);
    cfg_chk("R7 locked", 6'h0B, 32'h0000_00EF);
    cfg_wr(6'h0B, 4'b0010, 32'h0000_1100);
    cfg_chk("R7 locked high", 6'h0B, 32'h0000_00EF);

    // R1 R7: reset clears lock and base
    do_reset();
    cfg_chk("R1 base after reset", 6'h08, 32'h0000_0001);
    cfg_chk("R1 svid after reset", 6'h0B, 32'h0);
    cfg_wr(6'h0B, 4'b0011, 32'h0000_5A3C);
    cfg_chk("R7 write after reset", 6'h0B, 32'h0000_5A3C);
    cfg_wr(6'h0B, 4'b0011, 32'h0000_0000);
    cfg_chk("R7 relocked", 6'h0B, 32'h0000_5A3C);

    finish_run();
  end
endmodule